// File: doc/BRIEF.md
# Serial Flash Power-Mode Front End

This block sits at the serial port of a flash memory slave. It takes in instruction bytes and decides which of them reach the rest of the device. It also sequences the power states of the device. Serial clock, chip select and data input are sampled on the system clock `clk_i`. The serial clock runs in mode 0, so a bit is taken on each rising serial-clock edge. The first byte of every frame is the opcode. When it is accepted, the block passes it downstream as a one-cycle strobe together with its value.

Opcode 0xB9 puts the device into deep power-down. It is committed only when the frame ends exactly after its eighth bit and no program or erase cycle is reported busy. A programmable entry delay then runs, and after it the low-power enable turns on. In deep power-down the block forwards only the release opcode 0xAB. A 0xAB frame that closes on a byte boundary wakes the device. After three dummy bytes, the same opcode also shifts out a device identifier, whether or not the device was asleep. A programmable wake delay must pass before new instructions are accepted again.

Top module: `spi_pm_top`

## Requirements
- R1: After reset is released, `pwr_state_o` is 2'b00 (standby), and `lp_en_o`, `do_oe_o` and `cmd_vld_o` are all 0.
- R2: Outside the deep power-down states, `pwr_state_o` is 2'b01 (active) while chip select is low or `busy_i` is high. It is 2'b00 when chip select is high and `busy_i` is low.
- R3: Data input bits are taken MSB first on rising serial-clock edges. When the block is in standby or active, the first byte of a frame is forwarded: `cmd_vld_o` pulses for one clock and `cmd_op_o` holds the opcode. Later bytes of the frame are never forwarded.
- R4: Opcode 0xB9 commits only when chip select rises after exactly 8 bits of the frame. A rise after 7, 9 or 16 bits leaves the device out of deep power-down.
- R5: A 0xB9 frame that ends while `busy_i` is high is dropped, and the device stays out of deep power-down.
- R6: After a committed 0xB9, `pwr_state_o` reads 2'b01 for TDP_CYC clocks. It then changes to 2'b10 (deep power-down), and `lp_en_o` goes to 1 in the same cycle.
- R7: In deep power-down, every opcode except 0xAB is filtered out. No `cmd_vld_o` pulse appears for it, and the state stays at 2'b10 (this includes 0xB9 and write, program and erase opcodes).
- R8: After opcode 0xAB and three dummy bytes, DEV_ID is driven MSB first on `do_o`, changing on falling serial-clock edges. It repeats every 8 bits while chip select stays low. `do_oe_o` is 1 only during this output and is 0 during the dummy bytes and while chip select is high.
- R9: Deep power-down is left only on a chip-select rise after a 0xAB frame whose bit count is a nonzero multiple of 8. The state then reads 2'b11 (waking) for TRES_CYC clocks and then 2'b00, and `lp_en_o` drops when waking begins. A rise off a byte boundary leaves the device asleep.
- R10: While the state is 2'b11, every opcode is filtered out, including opcodes sent in a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| cs_ni | input | 1 | Chip select, active low |
| di_i | input | 1 | Serial data input |
| busy_i | input | 1 | Program/erase/write cycle in progress |
| do_o | output | 1 | Serial data output |
| do_oe_o | output | 1 | Output enable for `do_o` |
| cmd_vld_o | output | 1 | One-cycle strobe for a forwarded opcode |
| cmd_op_o | output | 8 | Forwarded opcode value |
| pwr_state_o | output | 2 | 00 standby, 01 active, 10 deep power-down, 11 waking |
| lp_en_o | output | 1 | Low-power enable |

## Verification
The bench ends 0xB9 frames after 7, 9 and 16 bits. A design that counted bits modulo 8, or that committed once the opcode byte was complete, would fall asleep on one of these frames. The bench sends 0xB9 while `busy_i` is high, and also sends 0xB9 and write-type opcodes during deep power-down. A filter that was too loose would produce a strobe or a state change that is caught. It samples the state one clock before and one clock after each delay should expire, so an off-by-one counter is detected. It also reads the identifier twice across the repeat boundary, and reads it once in standby to make sure reading it there does not start a wake.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_SLEEP = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    PS_STBY,
    PS_ACT,
    PS_ENTER,
    PS_DPD,
    PS_WAKE
  } pm_state_e;

  localparam logic [1:0] CODE_STBY = 2'b00;
  localparam logic [1:0] CODE_ACT  = 2'b01;
  localparam logic [1:0] CODE_DPD  = 2'b10;
  localparam logic [1:0] CODE_WAKE = 2'b11;
endpackage

// File: rtl/spi_pm_frame.sv
module spi_pm_frame
  import spi_pm_pkg::*;
#(
  parameter int unsigned BCW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              di_i,
  output logic              cs_rise_o,
  output logic              sck_fall_o,
  output logic              op_done_o,
  output logic [OP_W-1:0]   op_next_o,
  output logic [$clog2(OP_W)-1:0] bit_idx_o,
  output logic [BCW-1:0]    byte_cnt_o
);
  localparam int unsigned BIT_W = $clog2(OP_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OP_W - 1);
  localparam logic [BCW-1:0] BYTE_SAT = '1;

  logic sck_q, cs_q;
  logic sck_rise;
  logic [OP_W-1:0]  sh_q;
  logic [BIT_W-1:0] bit_q;
  logic [BCW-1:0]   byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign sck_rise   = sck_i & ~sck_q & ~cs_ni;
  assign sck_fall_o = ~sck_i & sck_q & ~cs_ni;
  assign cs_rise_o  = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
    end else if (cs_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (sck_rise) begin
      sh_q <= op_next_o;
      if (bit_q == LAST_BIT) begin
        bit_q <= '0;
        if (byte_q != BYTE_SAT) byte_q <= byte_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign op_next_o  = {sh_q[OP_W-2:0], di_i};
  assign op_done_o  = sck_rise && (bit_q == LAST_BIT) && (byte_q == '0);
  assign bit_idx_o  = bit_q;
  assign byte_cnt_o = byte_q;

  // R4
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_q == '0 && byte_q == '0));
endmodule

// File: rtl/spi_pm_ctrl.sv
module spi_pm_ctrl
  import spi_pm_pkg::*;
#(
  parameter int unsigned TDP_CYC  = 24,
  parameter int unsigned TRES_CYC = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_low_i,
  input  logic       busy_i,
  input  logic       sleep_frame_i,
  input  logic       wake_frame_i,
  output logic       accept_all_o,
  output logic       accept_wake_o,
  output logic [1:0] pwr_state_o,
  output logic       lp_en_o
);
  localparam int unsigned MAXD = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LD_DP  = CW'(TDP_CYC - 1);
  localparam logic [CW-1:0] LD_RES = CW'(TRES_CYC - 1);

  pm_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_STBY, PS_ACT: begin
        if (sleep_frame_i) begin
          st_d  = PS_ENTER;
          cnt_d = LD_DP;
        end else if (cs_low_i || busy_i) begin
          st_d = PS_ACT;
        end else begin
          st_d = PS_STBY;
        end
      end
      PS_ENTER: begin
        if (cnt_q == '0) st_d = PS_DPD;
        else cnt_d = cnt_q - 1'b1;
      end
      PS_DPD: begin
        if (wake_frame_i) begin
          st_d  = PS_WAKE;
          cnt_d = LD_RES;
        end
      end
      PS_WAKE: begin
        if (cnt_q == '0) st_d = PS_STBY;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PS_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PS_STBY;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      PS_STBY:          pwr_state_o = CODE_STBY;
      PS_ACT, PS_ENTER: pwr_state_o = CODE_ACT;
      PS_DPD:           pwr_state_o = CODE_DPD;
      PS_WAKE:          pwr_state_o = CODE_WAKE;
      default:          pwr_state_o = CODE_STBY;
    endcase
  end

  assign lp_en_o       = (st_q == PS_DPD);
  assign accept_all_o  = (st_q == PS_STBY) || (st_q == PS_ACT);
  assign accept_wake_o = (st_q == PS_DPD);

  // R6
  lp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_en_o) |-> $past(st_q) == PS_ENTER);
  // R5
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && st_q != PS_ENTER) |=> st_q != PS_ENTER);
  // R9
  dpd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_DPD) |=> (st_q == PS_DPD || st_q == PS_WAKE));
  // R9
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_WAKE) |=> (st_q == PS_WAKE || st_q == PS_STBY));
endmodule

// File: rtl/spi_pm_idout.sv
module spi_pm_idout
  import spi_pm_pkg::*;
#(
  parameter logic [OP_W-1:0] DEV_ID = 8'h5C
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sck_fall_i,
  input  logic                    id_phase_i,
  input  logic [$clog2(OP_W)-1:0] bit_idx_i,
  output logic                    do_o,
  output logic                    do_oe_o
);
  localparam int unsigned BIT_W = $clog2(OP_W);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(OP_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else if (cs_ni) begin
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else if (sck_fall_i && id_phase_i) begin
      do_o    <= DEV_ID[TOP_BIT - bit_idx_i];
      do_oe_o <= 1'b1;
    end
  end

  // R8
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !do_oe_o);
endmodule

// File: rtl/spi_pm_top.sv
module spi_pm_top
  import spi_pm_pkg::*;
#(
  parameter int unsigned      TDP_CYC     = 24,
  parameter int unsigned      TRES_CYC    = 64,
  parameter int unsigned      DUMMY_BYTES = 3,
  parameter logic [7:0]       DEV_ID      = 8'h5C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       di_i,
  input  logic       busy_i,
  output logic       do_o,
  output logic       do_oe_o,
  output logic       cmd_vld_o,
  output logic [7:0] cmd_op_o,
  output logic [1:0] pwr_state_o,
  output logic       lp_en_o
);
  localparam int unsigned BCW   = $clog2(DUMMY_BYTES + 3);
  localparam int unsigned BIT_W = $clog2(OP_W);
  localparam logic [BCW-1:0] ID_START = BCW'(DUMMY_BYTES + 1);

  logic              cs_rise, sck_fall, op_done;
  logic [OP_W-1:0]   op_next, op_q;
  logic [BIT_W-1:0]  bit_idx;
  logic [BCW-1:0]    byte_cnt;
  logic              acc_all, acc_wake, acc_now, op_acc_q;
  logic              on_boundary, sleep_frame, wake_frame, id_phase;

  spi_pm_frame #(.BCW(BCW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .di_i       (di_i),
    .cs_rise_o  (cs_rise),
    .sck_fall_o (sck_fall),
    .op_done_o  (op_done),
    .op_next_o  (op_next),
    .bit_idx_o  (bit_idx),
    .byte_cnt_o (byte_cnt)
  );

  assign acc_now = acc_all || (acc_wake && op_next == OP_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      op_acc_q  <= 1'b0;
      cmd_vld_o <= 1'b0;
      cmd_op_o  <= '0;
    end else begin
      cmd_vld_o <= op_done && acc_now;
      if (op_done) cmd_op_o <= op_next;
      if (cs_ni) begin
        op_acc_q <= 1'b0;
      end else if (op_done) begin
        op_q     <= op_next;
        op_acc_q <= acc_now;
      end
    end
  end

  assign on_boundary = (bit_idx == '0) && (byte_cnt != '0);
  assign sleep_frame = cs_rise && op_acc_q && (op_q == OP_SLEEP)
                     && (bit_idx == '0) && (byte_cnt == BCW'(1)) && !busy_i;
  assign wake_frame  = cs_rise && op_acc_q && (op_q == OP_WAKE) && on_boundary;
  assign id_phase    = op_acc_q && (op_q == OP_WAKE) && (byte_cnt >= ID_START);

  spi_pm_ctrl #(.TDP_CYC(TDP_CYC), .TRES_CYC(TRES_CYC)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_low_i      (!cs_ni),
    .busy_i        (busy_i),
    .sleep_frame_i (sleep_frame),
    .wake_frame_i  (wake_frame),
    .accept_all_o  (acc_all),
    .accept_wake_o (acc_wake),
    .pwr_state_o   (pwr_state_o),
    .lp_en_o       (lp_en_o)
  );

  spi_pm_idout #(.DEV_ID(DEV_ID)) u_idout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_fall_i (sck_fall),
    .id_phase_i (id_phase),
    .bit_idx_i  (bit_idx),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
  );

  // R7
  dpd_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && lp_en_o) |-> cmd_op_o == OP_WAKE);
  // R10
  wake_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == CODE_WAKE && $past(pwr_state_o) == CODE_WAKE) |-> !cmd_vld_o);
endmodule

// File: tb/tb_spi_pm_top.sv
module tb_spi_pm_top;
  localparam int TDP  = 24;
  localparam int TRES = 64;
  localparam int HP   = 2;
  localparam logic [7:0] ID = 8'h5C;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck_i = 1'b0, cs_ni = 1'b1, di_i = 1'b0, busy_i = 1'b0;
  logic do_o, do_oe_o, cmd_vld_o, lp_en_o;
  logic [7:0] cmd_op_o;
  logic [1:0] pwr_state_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string cur_req = "R3";

  always #4 clk = ~clk;

  spi_pm_top #(.TDP_CYC(TDP), .TRES_CYC(TRES), .DUMMY_BYTES(3), .DEV_ID(ID)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .cs_ni(cs_ni), .di_i(di_i),
    .busy_i(busy_i), .do_o(do_o), .do_oe_o(do_oe_o), .cmd_vld_o(cmd_vld_o),
    .cmd_op_o(cmd_op_o), .pwr_state_o(pwr_state_o), .lp_en_o(lp_en_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_ni && cmd_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected forwarded opcode", int'(cmd_op_o), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cmd_op_o == e, cur_req, "forwarded opcode", int'(cmd_op_o), int'(e));
      end
    end
  end

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, "missing forwarded opcode", exp_q.size(), 0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_ni = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_hi();
    wait_clk(HP);
    cs_ni = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < n; i++) begin
      di_i = b[7 - (i % 8)];
      wait_clk(HP);
      rd = {rd[6:0], do_o};
      sck_i = 1'b1;
      wait_clk(HP);
      sck_i = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nbits, input bit expect_fwd);
    logic [7:0] rd;
    if (expect_fwd && nbits >= 8) exp_q.push_back(op);
    cs_lo();
    send_bits(op, nbits > 8 ? 8 : nbits, rd);
    if (nbits > 8) send_bits(op, nbits - 8, rd);
    cs_hi();
  endtask

  task automatic chk_state(input string req, input logic [1:0] st, input logic lp);
    chk(pwr_state_o == st, req, "pwr_state_o", int'(pwr_state_o), int'(st));
    chk(lp_en_o == lp, req, "lp_en_o", int'(lp_en_o), int'(lp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk_state("R1", 2'b00, 1'b0);
    chk(do_oe_o == 1'b0, "R1", "do_oe_o", int'(do_oe_o), 0);
    chk(cmd_vld_o == 1'b0, "R1", "cmd_vld_o", int'(cmd_vld_o), 0);

    // R2 active while selected or busy
    cs_lo();
    chk_state("R2", 2'b01, 1'b0);
    cs_hi();
    wait_clk(2);
    chk_state("R2", 2'b00, 1'b0);
    busy_i = 1'b1;
    wait_clk(2);
    chk_state("R2", 2'b01, 1'b0);
    busy_i = 1'b0;
    wait_clk(2);
    chk_state("R2", 2'b00, 1'b0);

    // R3 forwarding, only the first byte of a frame
    cur_req = "R3";
    frame(8'h06, 8, 1'b1);
    wait_clk(2);
    drained("R3");
    exp_q.push_back(8'h03);
    cs_lo();
    send_bits(8'h03, 8, rd);
    send_bits(8'h12, 8, rd);
    cs_hi();
    wait_clk(2);
    drained("R3");

    // R4 framing off by one bit either side, or a whole extra byte
    cur_req = "R4";
    frame(8'hB9, 7, 1'b0);
    wait_clk(TDP + 4);
    chk_state("R4", 2'b00, 1'b0);
    frame(8'hB9, 9, 1'b1);
    wait_clk(TDP + 4);
    chk_state("R4", 2'b00, 1'b0);
    frame(8'hB9, 16, 1'b1);
    wait_clk(TDP + 4);
    chk_state("R4", 2'b00, 1'b0);
    drained("R4");

    // R5 sleep request dropped while busy
    cur_req = "R5";
    busy_i = 1'b1;
    frame(8'hB9, 8, 1'b1);
    wait_clk(TDP + 4);
    chk_state("R5", 2'b01, 1'b0);
    busy_i = 1'b0;
    wait_clk(2);
    chk_state("R5", 2'b00, 1'b0);

    // R6 entry delay exact length
    cur_req = "R6";
    frame(8'hB9, 8, 1'b1);
    repeat (TDP) @(posedge clk);
    @(negedge clk);
    chk_state("R6", 2'b01, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk_state("R6", 2'b10, 1'b1);

    // R7 filter in deep power-down
    cur_req = "R7";
    frame(8'h06, 8, 1'b0);
    frame(8'h02, 8, 1'b0);
    frame(8'hD8, 8, 1'b0);
    frame(8'hB9, 8, 1'b0);
    wait_clk(TDP + 4);
    chk_state("R7", 2'b10, 1'b1);
    drained("R7");

    // R9 release off a byte boundary keeps sleeping
    cur_req = "R9";
    frame(8'hAB, 11, 1'b1);
    wait_clk(TRES + 4);
    chk_state("R9", 2'b10, 1'b1);

    // R8 ID output with release, then R9 exit timing
    cur_req = "R8";
    exp_q.push_back(8'hAB);
    cs_lo();
    send_bits(8'hAB, 8, rd);
    send_bits(8'h00, 8, rd);
    send_bits(8'h00, 8, rd);
    chk(do_oe_o == 1'b0, "R8", "do_oe_o in dummy bytes", int'(do_oe_o), 0);
    send_bits(8'h00, 8, rd);
    send_bits(8'h00, 8, rd);
    chk(rd == ID, "R8", "device id first", int'(rd), int'(ID));
    chk(do_oe_o == 1'b1, "R8", "do_oe_o during id", int'(do_oe_o), 1);
    send_bits(8'h00, 8, rd);
    chk(rd == ID, "R8", "device id repeat", int'(rd), int'(ID));
    chk_state("R9", 2'b10, 1'b1);
    cs_hi();
    repeat (TRES) @(posedge clk);
    @(negedge clk);
    chk_state("R9", 2'b11, 1'b0);
    chk(do_oe_o == 1'b0, "R8", "do_oe_o deselected", int'(do_oe_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk_state("R9", 2'b00, 1'b0);
    drained("R8");

    // R10 nothing accepted while waking
    cur_req = "R10";
    frame(8'hB9, 8, 1'b1);
    wait_clk(TDP + 2);
    chk_state("R10", 2'b10, 1'b1);
    frame(8'hAB, 8, 1'b1);
    frame(8'h06, 8, 1'b0);
    wait_clk(1);
    chk_state("R10", 2'b11, 1'b0);
    drained("R10");
    wait_clk(TRES);
    chk_state("R10", 2'b00, 1'b0);
    cur_req = "R3";
    frame(8'h06, 8, 1'b1);
    wait_clk(2);
    drained("R3");

    // R8 id readout in standby causes no wake sequence
    cur_req = "R8";
    exp_q.push_back(8'hAB);
    cs_lo();
    send_bits(8'hAB, 8, rd);
    for (int k = 0; k < 3; k++) send_bits(8'h00, 8, rd);
    send_bits(8'h00, 8, rd);
    chk(rd == ID, "R8", "device id in standby", int'(rd), int'(ID));
    cs_hi();
    wait_clk(3);
    chk_state("R8", 2'b00, 1'b0);
    drained("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule